// File: doc/BRIEF.md
# Fixed Off-Time Winding Current Chopper

This block is the digital sequencer for one H-bridge that drives a single motor winding. A direction input selects which diagonal pair of switches conducts. A nonzero current-level code enables the bridge. An external comparator reports when the winding current has reached its trip point. When that happens, the block opens the conducting diagonal for a fixed number of clock cycles and then closes it again. The result is a peak-regulated chopping waveform on four gate-enable outputs.

The off interval can decay the current in three ways:
- **Recirculating:** both low-side switches are on.
- **Regenerative:** the opposite diagonal is on.
- **Split:** regenerative for a programmable count, then recirculating for the rest of the off interval.

After every switching event the comparator is masked for a programmable blanking count. A direction change forces all switches open for a programmable dead time before the new diagonal closes. A level code of zero, or an asserted fault, opens every switch. All interval lengths are counts of clock cycles supplied as inputs. Each count is sampled when its interval begins.

Top module: `hbridge_chopper`

## Requirements
- R1: While conducting, the gate pattern {hs_a, ls_a, hs_b, ls_b} is 1001 when dir_i=1 and 0110 when dir_i=0.
- R2: trip_i passes through a two-stage synchronizer and only acts while conducting with blanking expired. With trip_i held low, the conducting pattern persists indefinitely.
- R3: With decay_sel_i=00, the off interval shows pattern 0101 (both high sides off, both low sides on) for toff_cyc_i cycles.
- R4: With decay_sel_i=01, the off interval drives the opposite diagonal (0110 for dir_i=1, 1001 for dir_i=0) for toff_cyc_i cycles.
- R5: With decay_sel_i=10 or 11, the off interval drives the opposite diagonal for min(tfast_cyc_i, toff_cyc_i) cycles and then shows 0101 for the remainder. A fast count of 0 gives a fully recirculating off interval.
- R6: Each off interval is followed by conduction on the original diagonal. The trip is ignored for tblank_cyc_i cycles after every entry into conduction, so a trip held high gives conduction runs of exactly tblank_cyc_i+1 cycles.
- R7: A change of dir_i while the bridge is active opens all four switches from the next cycle for tdead_cyc_i cycles. Conduction in the new direction then follows, with blanking.
- R8: Reset, or level_i=000, gives pattern 0000 from the next cycle. Leaving 000 starts conduction on the next cycle, with blanking.
- R9: fault_i=1 gives pattern 0000 from the next cycle for as long as it is held. Conduction resumes, with blanking, the cycle after it clears.
- R10: The high-side and low-side switch of the same leg are never enabled together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Asynchronous current-trip comparator output |
| dir_i | input | 1 | Winding current direction, 1 = leg A to leg B |
| level_i | input | 3 | Current-level code, 000 disables the bridge |
| decay_sel_i | input | 2 | Off-interval decay: 00 recirculate, 01 regenerate, 1x split |
| fault_i | input | 1 | Thermal or undervoltage fault, forces all switches open |
| toff_cyc_i | input | COUNT_W | Off interval length in cycles |
| tfast_cyc_i | input | COUNT_W | Regenerative portion of a split off interval |
| tblank_cyc_i | input | COUNT_W | Comparator blanking length in cycles |
| tdead_cyc_i | input | COUNT_W | Dead time on a direction change, in cycles |
| hs_a_o | output | 1 | Leg A high-side enable |
| ls_a_o | output | 1 | Leg A low-side enable |
| hs_b_o | output | 1 | Leg B high-side enable |
| ls_b_o | output | 1 | Leg B low-side enable |

## Verification
The bench builds the block with COUNT_W=5 and the default two-stage synchronizer. It programs an off interval of 6, a blanking count of 3 and a dead time of 4 cycles. With a trip held high, each chop period is ten cycles, so several full periods per decay mode fit into a few hundred cycles. Fast counts of 2, 0 and 9 reach the split handover, the all-recirculating corner and the case where the fast count exceeds the off interval. Direction flips and faults injected mid-conduction expose the dead time and the blanked restart.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEAD     = 3'd1,
    ST_ON       = 3'd2,
    ST_OFF_FAST = 3'd3,
    ST_OFF_SLOW = 3'd4
  } chop_state_e;

  localparam logic [1:0] DECAY_SLOW = 2'b00;
  localparam logic [1:0] DECAY_FAST = 2'b01;

  typedef struct packed {
    logic hs_a;
    logic ls_a;
    logic hs_b;
    logic ls_b;
  } gate_set_t;

  // Split decay is selected by either code with the upper bit set.
  function automatic logic decay_is_split(input logic [1:0] sel);
    return (sel == 2'b10) || (sel == 2'b11);
  endfunction

  // Conducting diagonal for a given current direction.
  function automatic gate_set_t diag_for(input logic fwd);
    gate_set_t g;
    g = '0;
    if (fwd) begin
      g.hs_a = 1'b1;
      g.ls_b = 1'b1;
    end else begin
      g.hs_b = 1'b1;
      g.ls_a = 1'b1;
    end
    return g;
  endfunction

  function automatic gate_set_t gates_for(input chop_state_e st, input logic dir);
    gate_set_t g;
    g = '0;
    case (st)
      ST_ON:       g = diag_for(dir);
      ST_OFF_FAST: g = diag_for(!dir);
      ST_OFF_SLOW: begin
        g.ls_a = 1'b1;
        g.ls_b = 1'b1;
      end
      default:     g = '0;
    endcase
    return g;
  endfunction

  // First phase of an off interval, chosen from the decay code at its start.
  function automatic chop_state_e off_entry_state(input logic [1:0] sel,
                                                  input logic fast_nonzero);
    if (sel == DECAY_FAST) return ST_OFF_FAST;
    if (decay_is_split(sel) && fast_nonzero) return ST_OFF_FAST;
    return ST_OFF_SLOW;
  endfunction

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[N-2:0], d};
  end

  assign q = sh[N-1];
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/chop_gate_decode.sv
module chop_gate_decode
  import chop_pkg::*;
(
  input  chop_state_e state,
  input  logic        dir,
  output gate_set_t   gates
);
  assign gates = gates_for(state, dir);
endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
  import chop_pkg::*;
#(
  parameter int COUNT_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trip_i,
  input  logic               dir_i,
  input  logic [2:0]         level_i,
  input  logic [1:0]         decay_sel_i,
  input  logic               fault_i,
  input  logic [COUNT_W-1:0] toff_cyc_i,
  input  logic [COUNT_W-1:0] tfast_cyc_i,
  input  logic [COUNT_W-1:0] tblank_cyc_i,
  input  logic [COUNT_W-1:0] tdead_cyc_i,
  output logic               hs_a_o,
  output logic               ls_a_o,
  output logic               hs_b_o,
  output logic               ls_b_o
);
  localparam int NUM_T   = 3;
  localparam int T_MAIN  = 0;  // dead time and whole off interval
  localparam int T_FAST  = 1;  // regenerative part of a split off interval
  localparam int T_BLANK = 2;  // comparator mask after switching

  // An interval of n cycles preloads n-1; zero behaves as one cycle.
  function automatic logic [COUNT_W-1:0] span_load(input logic [COUNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  chop_state_e state_q, state_d;
  logic        dir_q, dir_d;
  logic        mixed_q, mixed_d;

  logic [NUM_T-1:0]   t_ld;
  logic [NUM_T-1:0]   t_zero;
  logic [COUNT_W-1:0] t_val [NUM_T];

  // Named internal events
  logic      trip_s;
  logic      level_off;
  logic      quiet;
  logic      dir_flip;
  logic      blank_zero, main_zero, fast_zero;
  logic      st_on, st_fast, st_slow, st_dead;
  logic      trip_take;
  logic      off_entry;
  logic      on_entry;
  gate_set_t gates;

  chop_sync #(.STAGES(SYNC_STAGES)) u_trip_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (trip_i),
    .q     (trip_s)
  );

  for (genvar i = 0; i < NUM_T; i++) begin : g_timer
    chop_timer #(.W(COUNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_ld[i]),
      .load_val (t_val[i]),
      .zero     (t_zero[i])
    );
  end

  assign main_zero  = t_zero[T_MAIN];
  assign fast_zero  = t_zero[T_FAST];
  assign blank_zero = t_zero[T_BLANK];

  assign level_off = (level_i == '0);
  assign quiet     = fault_i || level_off;
  assign dir_flip  = (dir_i != dir_q);
  assign st_on     = (state_q == ST_ON);
  assign st_fast   = (state_q == ST_OFF_FAST);
  assign st_slow   = (state_q == ST_OFF_SLOW);
  assign st_dead   = (state_q == ST_DEAD);
  assign trip_take = st_on && blank_zero && trip_s;
  assign on_entry  = t_ld[T_BLANK];
  assign off_entry = t_ld[T_FAST];

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    mixed_d = mixed_q;
    t_ld    = '0;
    for (int i = 0; i < NUM_T; i++) t_val[i] = '0;

    if (quiet) begin
      state_d = ST_IDLE;
    end else if (state_q == ST_IDLE) begin
      state_d        = ST_ON;
      dir_d          = dir_i;
      t_ld[T_BLANK]  = 1'b1;
      t_val[T_BLANK] = tblank_cyc_i;
    end else if (dir_flip) begin
      state_d       = ST_DEAD;
      dir_d         = dir_i;
      t_ld[T_MAIN]  = 1'b1;
      t_val[T_MAIN] = span_load(tdead_cyc_i);
    end else begin
      case (state_q)
        ST_DEAD: begin
          if (main_zero) begin
            state_d        = ST_ON;
            t_ld[T_BLANK]  = 1'b1;
            t_val[T_BLANK] = tblank_cyc_i;
          end
        end
        ST_ON: begin
          if (trip_take) begin
            state_d       = off_entry_state(decay_sel_i, tfast_cyc_i != '0);
            mixed_d       = decay_is_split(decay_sel_i);
            t_ld[T_MAIN]  = 1'b1;
            t_val[T_MAIN] = span_load(toff_cyc_i);
            t_ld[T_FAST]  = 1'b1;
            t_val[T_FAST] = span_load(tfast_cyc_i);
          end
        end
        ST_OFF_FAST: begin
          if (main_zero) begin
            state_d        = ST_ON;
            t_ld[T_BLANK]  = 1'b1;
            t_val[T_BLANK] = tblank_cyc_i;
          end else if (mixed_q && fast_zero) begin
            state_d = ST_OFF_SLOW;
          end
        end
        ST_OFF_SLOW: begin
          if (main_zero) begin
            state_d        = ST_ON;
            t_ld[T_BLANK]  = 1'b1;
            t_val[T_BLANK] = tblank_cyc_i;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      mixed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      mixed_q <= mixed_d;
    end
  end

  chop_gate_decode u_decode (
    .state (state_q),
    .dir   (dir_q),
    .gates (gates)
  );

  assign hs_a_o = gates.hs_a;
  assign ls_a_o = gates.ls_a;
  assign hs_b_o = gates.hs_b;
  assign ls_b_o = gates.ls_b;

endmodule

// File: rtl/chop_checker.sv
module chop_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_i,
  input logic       level_off,
  input logic       dir_i,
  input logic       dir_q,
  input logic [3:0] gates,
  input logic       st_on,
  input logic       st_fast,
  input logic       st_slow,
  input logic       blank_zero,
  input logic       main_zero,
  input logic       fast_zero,
  input logic       mixed_q
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R10: no leg ever has both switches closed
  assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(gates[3] && gates[2]) && !(gates[1] && gates[0]));

  // R9: a fault opens every switch on the next cycle
  assert_fault_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (gates == 4'b0000));

  // R8: level code zero opens every switch on the next cycle
  assert_level_zero_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    level_off |=> (gates == 4'b0000));

  // R6: while blanking runs, conduction never turns into an off interval
  assert_blank_masks_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_on && !blank_zero) |=> !(st_fast || st_slow));

  // R7: a direction change on an active bridge opens all switches next cycle
  assert_dir_change_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (dir_i != $past(dir_i)) && (gates != 4'b0000)) |=> (gates == 4'b0000));

  // R5: split decay hands over to recirculation when the fast count runs out
  assert_split_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fast && mixed_q && fast_zero && !main_zero && !fault_i && !level_off
     && (dir_i == dir_q)) |=> st_slow);

endmodule

bind hbridge_chopper chop_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_i    (fault_i),
  .level_off  (level_off),
  .dir_i      (dir_i),
  .dir_q      (dir_q),
  .gates      ({hs_a_o, ls_a_o, hs_b_o, ls_b_o}),
  .st_on      (st_on),
  .st_fast    (st_fast),
  .st_slow    (st_slow),
  .blank_zero (blank_zero),
  .main_zero  (main_zero),
  .fast_zero  (fast_zero),
  .mixed_q    (mixed_q)
);

// File: tb/hbridge_chopper_tb.sv
module hbridge_chopper_tb;
  localparam int CW     = 5;
  localparam int TOFF   = 6;
  localparam int TBLANK = 3;
  localparam int TDEAD  = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trip, dir, fault;
  logic [2:0]    level;
  logic [1:0]    dsel;
  logic [CW-1:0] toff, tfast, tblank, tdead;
  logic          hs_a, ls_a, hs_b, ls_b;

  always #10 clk = ~clk;

  hbridge_chopper #(.COUNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_i       (trip),
    .dir_i        (dir),
    .level_i      (level),
    .decay_sel_i  (dsel),
    .fault_i      (fault),
    .toff_cyc_i   (toff),
    .tfast_cyc_i  (tfast),
    .tblank_cyc_i (tblank),
    .tdead_cyc_i  (tdead),
    .hs_a_o       (hs_a),
    .ls_a_o       (ls_a),
    .hs_b_o       (hs_b),
    .ls_b_o       (ls_b)
  );

  wire [3:0] g_obs = {hs_a, ls_a, hs_b, ls_b};

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;

  // Scoreboard: expected gate segments (pattern, length; length 0 = any)
  logic [3:0] pat_q[$];
  int         len_q[$];
  string      tag_q[$];

  task automatic push_exp(input logic [3:0] p, input int l, input string t);
    pat_q.push_back(p);
    len_q.push_back(l);
    tag_q.push_back(t);
  endtask

  task automatic close_run(input logic [3:0] p, input int l);
    logic [3:0] ep;
    int         el;
    string      et;
    n_chk++;
    if (pat_q.size() == 0) begin
      n_fail++;
      $display("FAIL R1: unexpected segment %b len %0d, expected none", p, l);
    end else begin
      ep = pat_q.pop_front();
      el = len_q.pop_front();
      et = tag_q.pop_front();
      if (p != ep || (el != 0 && l != el)) begin
        n_fail++;
        $display("FAIL %s: segment %b len %0d, expected %b len %0d", et, p, l, ep, el);
      end
    end
  endtask

  // Monitor: collects runs of constant gate pattern at the falling edge
  initial begin
    logic [3:0] cur;
    int         len;
    wait (mon_en);
    @(negedge clk);
    cur = g_obs;
    len = 1;
    forever begin
      @(negedge clk);
      n_chk++;
      if ((g_obs[3] && g_obs[2]) || (g_obs[1] && g_obs[0])) begin
        n_fail++;
        $display("FAIL R10: gates %b, expected no leg with both switches on", g_obs);
      end
      if (g_obs == cur) len++;
      else begin
        close_run(cur, len);
        cur = g_obs;
        len = 1;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Trip held high: every conduction lasts TBLANK+1 cycles (R6)
  task automatic run_periodic(input logic d, input logic [1:0] m, input int nper,
                              input string tag);
    logic [3:0] on_p, opp_p;
    int fl, period;
    on_p   = d ? 4'b1001 : 4'b0110;
    opp_p  = d ? 4'b0110 : 4'b1001;
    period = TBLANK + 1 + TOFF;
    fl     = (int'(tfast) < TOFF) ? int'(tfast) : TOFF;
    for (int p = 0; p < nper; p++) begin
      push_exp(on_p, TBLANK + 1, "R6");
      if (m == 2'b00)      push_exp(4'b0101, TOFF, tag);
      else if (m == 2'b01) push_exp(opp_p, TOFF, tag);
      else begin
        if (fl > 0)        push_exp(opp_p, fl, tag);
        if (TOFF - fl > 0) push_exp(4'b0101, TOFF - fl, tag);
      end
    end
    push_exp(on_p, 1, "R1");
    push_exp(4'b0000, 0, "R8");
    @(posedge clk); #2;
    dir = d; dsel = m; level = 3'b101;
    repeat (nper * period + 1) @(posedge clk);
    #2 level = 3'b000;
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R2: watchdog expired, actual hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; trip = 1'b0; dir = 1'b0; fault = 1'b0;
    level = 3'b000; dsel = 2'b00;
    toff = CW'(TOFF); tfast = CW'(2); tblank = CW'(TBLANK); tdead = CW'(TDEAD);
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (g_obs != 4'b0000) begin
      n_fail++;
      $display("FAIL R8: reset gates %b, expected 0000", g_obs);
    end
    push_exp(4'b0000, 0, "R8");
    rst_n  = 1'b1;
    mon_en = 1'b1;
    trip   = 1'b1;
    repeat (4) @(posedge clk);

    run_periodic(1'b1, 2'b00, 2, "R3");
    run_periodic(1'b0, 2'b00, 1, "R3");
    run_periodic(1'b1, 2'b01, 2, "R4");
    run_periodic(1'b0, 2'b01, 1, "R4");
    run_periodic(1'b1, 2'b10, 2, "R5");
    run_periodic(1'b0, 2'b11, 1, "R5");
    tfast = CW'(0);
    run_periodic(1'b1, 2'b10, 1, "R5");
    tfast = CW'(9);
    run_periodic(1'b0, 2'b10, 1, "R5");
    tfast = CW'(2);

    // R7: direction flip in the second conduction run
    push_exp(4'b1001, 4, "R6");
    push_exp(4'b0101, 6, "R3");
    push_exp(4'b1001, 1, "R7");
    push_exp(4'b0000, TDEAD, "R7");
    push_exp(4'b0110, 4, "R7");
    push_exp(4'b0101, 6, "R3");
    push_exp(4'b0110, 1, "R1");
    push_exp(4'b0000, 0, "R8");
    @(posedge clk); #2;
    dir = 1'b1; dsel = 2'b00; level = 3'b011;
    repeat (11) @(posedge clk);
    #2 dir = 1'b0;
    repeat (15) @(posedge clk);
    #2 level = 3'b000;
    repeat (5) @(posedge clk);

    // R9: fault held for five cycles during conduction, regenerative decay
    push_exp(4'b0110, 4, "R6");
    push_exp(4'b1001, 6, "R4");
    push_exp(4'b0110, 1, "R9");
    push_exp(4'b0000, 5, "R9");
    push_exp(4'b0110, 4, "R9");
    push_exp(4'b1001, 6, "R4");
    push_exp(4'b0110, 1, "R1");
    push_exp(4'b0000, 0, "R8");
    @(posedge clk); #2;
    dir = 1'b0; dsel = 2'b01; level = 3'b111;
    repeat (11) @(posedge clk);
    #2 fault = 1'b1;
    repeat (5) @(posedge clk);
    #2 fault = 1'b0;
    repeat (11) @(posedge clk);
    #2 level = 3'b000;
    repeat (5) @(posedge clk);

    // R2: trip low, conduction holds for the whole enable window
    trip = 1'b0;
    repeat (4) @(posedge clk);
    push_exp(4'b1001, 20, "R2");
    push_exp(4'b0000, 0, "R8");
    @(posedge clk); #2;
    dir = 1'b1; level = 3'b001;
    repeat (20) @(posedge clk);
    #2 level = 3'b000;
    repeat (6) @(posedge clk);

    n_chk++;
    if (pat_q.size() != 1) begin
      n_fail++;
      $display("FAIL R1: %0d segments outstanding, expected 1", pat_q.size());
    end
    summary();
    $finish;
  end
endmodule